// File: doc/BRIEF.md
# Extended Register Bank Mapper

This block holds a file of byte-wide extended configuration registers for a VGA-class display controller. It sits on an 8-bit I/O bus and is reached through two ports. Writing the index port chooses one of 256 registers. An access to the data port then reads or writes the chosen register. The index port also reads back the current index.

Two registers set where the host's memory window falls in video memory. A bank register holds a read-bank field and a write-bank field. One bit of a mode register picks how they are used. In shared mode, one field sets both banks. In split mode, the read side and the write side each follow their own field. Each bank number selects a 64 KiB granule, so eight banks cover 512 KiB. The block outputs the resulting base addresses.

A third register drives the chip-select, clock and data-in lines of a serial EEPROM that software toggles bit by bit. A fourth register, when read, shows the EEPROM's data-out pin in one of its bits.

Top module: `ext_reg_bank_mapper`

## Requirements
- R1: A write strobe at address 0x01CE loads io_wdata into the index register. A read strobe at 0x01CE returns the current index on io_rdata.
- R2: A write strobe at address 0x01CF stores io_wdata in the register chosen by the index. A read at 0x01CF returns that stored byte. This holds for every register except 0xB7.
- R3: When bit 3 of register 0xBE is 1 (split mode), the read bank number is bits 7:5 of register 0xB2 and the write bank number is bits 3:1 of register 0xB2.
- R4: When bit 3 of register 0xBE is 0 (shared mode), both bank numbers are bits 3:1 of register 0xB2, and the other bits of 0xBE have no effect.
- R5: rd_bank_base and wr_bank_base are 19 bits wide and equal the bank number times 0x10000. They change on the clock edge that writes register 0xB2 or 0xBE, and only on a write.
- R6: After a write to register 0xB3, ee_cs follows bit 3 of the written byte, ee_clk follows bit 1 and ee_din follows bit 0. The lines hold these levels until the next write to 0xB3.
- R7: A read of register 0xB7 returns its stored byte with bit 3 replaced by the current ee_dout level.
- R8: Reset clears the index and all 256 registers. Both bank bases and all EEPROM lines are then 0.
- R9: io_rdata is 0 whenever io_rd is low or the address is neither 0x01CE nor 0x01CF. A write to any other address changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 16 | I/O address |
| io_wdata | input | 8 | Write data |
| io_wr | input | 1 | Single-cycle write strobe |
| io_rd | input | 1 | Read strobe, with data returned in the same cycle |
| io_rdata | output | 8 | Read data |
| ee_dout | input | 1 | EEPROM data-out pin level |
| rd_bank_base | output | 19 | Base address of the read bank |
| wr_bank_base | output | 19 | Base address of the write bank |
| ee_cs | output | 1 | EEPROM chip select |
| ee_clk | output | 1 | EEPROM serial clock |
| ee_din | output | 1 | EEPROM data-in |

## Verification
The checker keeps its own copy of the index and of the two bank registers, built only from the bus writes it sees. Its properties therefore assume that every register change arrives as a write strobe at a decoded port address, with io_addr and io_wdata stable while the strobe is high. They also assume that io_wr and io_rd are never high in the same cycle. The stimulus drives each strobe for exactly one cycle, sets it between clock edges, and never overlaps a read with a write.

// File: rtl/xr_pkg.sv
package xr_pkg;
   typedef enum logic {
      BANK_SHARED = 1'b0,
      BANK_SPLIT  = 1'b1
   } bank_mode_e;

   // Decode one bus strobe against a port address.
   function automatic logic port_hit(input logic strobe, input logic [15:0] addr,
                                     input logic [15:0] port);
      return strobe && (addr == port);
   endfunction
endpackage

// File: rtl/xr_regfile.sv
module xr_regfile #(
   parameter int DATA_W = 8,
   parameter int IDX_W  = 8,
   localparam int DEPTH = 1 << IDX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              idx_we,
   input  logic              dat_we,
   input  logic [DATA_W-1:0] wdata,
   output logic [IDX_W-1:0]  idx_q,
   output logic [DATA_W-1:0] regs_q [DEPTH]
);
   logic [IDX_W-1:0] idx_next;
   assign idx_next = wdata[IDX_W-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n)      idx_q <= '0;
      else if (idx_we) idx_q <= idx_next;
   end

   for (genvar g = 0; g < DEPTH; g++) begin : g_entry
      always_ff @(posedge clk) begin
         if (!rst_n)                        regs_q[g] <= '0;
         else if (dat_we && idx_q == IDX_W'(g)) regs_q[g] <= wdata;
      end
   end
endmodule

// File: rtl/xr_bank_map.sv
module xr_bank_map
   import xr_pkg::*;
#(
   parameter int BANK_W   = 3,
   parameter int GRAN_W   = 16,
   parameter bit SPLIT_EN = 1'b1,
   localparam int BASE_W  = BANK_W + GRAN_W
) (
   input  logic              mode_bit,
   input  logic [BANK_W-1:0] rd_field,
   input  logic [BANK_W-1:0] wr_field,
   output logic [BASE_W-1:0] rd_base,
   output logic [BASE_W-1:0] wr_base
);
   bank_mode_e        mode;
   logic [BANK_W-1:0] rd_bank;
   logic [BANK_W-1:0] wr_bank;

   assign mode = bank_mode_e'(mode_bit);

   if (SPLIT_EN) begin : g_split
      always_comb begin
         wr_bank = wr_field;
         rd_bank = (mode == BANK_SPLIT) ? rd_field : wr_field;
      end
   end else begin : g_shared
      logic unused_split;
      assign unused_split = mode_bit ^ (^rd_field);
      always_comb begin
         wr_bank = wr_field;
         rd_bank = wr_field;
      end
   end

   assign rd_base = {rd_bank, {GRAN_W{1'b0}}};
   assign wr_base = {wr_bank, {GRAN_W{1'b0}}};
endmodule

// File: rtl/xr_eeprom_port.sv
module xr_eeprom_port #(
   parameter int DATA_W  = 8,
   parameter int CS_BIT  = 3,
   parameter int CLK_BIT = 1,
   parameter int DI_BIT  = 0,
   parameter int DO_BIT  = 3
) (
   input  logic [DATA_W-1:0] ctrl_byte,
   input  logic [DATA_W-1:0] stat_byte,
   input  logic              ee_dout,
   output logic              ee_cs,
   output logic              ee_clk,
   output logic              ee_din,
   output logic [DATA_W-1:0] stat_view
);
   assign ee_cs  = ctrl_byte[CS_BIT];
   assign ee_clk = ctrl_byte[CLK_BIT];
   assign ee_din = ctrl_byte[DI_BIT];

   always_comb begin
      stat_view         = stat_byte;
      stat_view[DO_BIT] = ee_dout;
   end
endmodule

// File: rtl/ext_reg_bank_mapper.sv
module ext_reg_bank_mapper
   import xr_pkg::*;
#(
   parameter int          DATA_W      = 8,
   parameter int          IDX_W       = 8,
   parameter logic [15:0] INDEX_PORT  = 16'h01CE,
   parameter logic [15:0] DATA_PORT   = 16'h01CF,
   parameter int          BANK_REG    = 8'hB2,
   parameter int          MODE_REG    = 8'hBE,
   parameter int          EE_CTRL_REG = 8'hB3,
   parameter int          EE_STAT_REG = 8'hB7,
   parameter int          MODE_BIT    = 3,
   parameter int          BANK_W      = 3,
   parameter int          RD_LSB      = 5,
   parameter int          WR_LSB      = 1,
   parameter int          GRAN_W      = 16,
   parameter bit          SPLIT_EN    = 1'b1,
   localparam int         BASE_W      = BANK_W + GRAN_W,
   localparam int         DEPTH       = 1 << IDX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [15:0]       io_addr,
   input  logic [DATA_W-1:0] io_wdata,
   input  logic              io_wr,
   input  logic              io_rd,
   output logic [DATA_W-1:0] io_rdata,
   input  logic              ee_dout,
   output logic [BASE_W-1:0] rd_bank_base,
   output logic [BASE_W-1:0] wr_bank_base,
   output logic              ee_cs,
   output logic              ee_clk,
   output logic              ee_din
);
   if (IDX_W > DATA_W) begin : g_err_idx
      $error("IDX_W must not exceed DATA_W");
   end
   if (RD_LSB + BANK_W > DATA_W || WR_LSB + BANK_W > DATA_W) begin : g_err_field
      $error("bank field exceeds register width");
   end
   if (BANK_REG >= DEPTH || MODE_REG >= DEPTH || EE_CTRL_REG >= DEPTH
       || EE_STAT_REG >= DEPTH) begin : g_err_reg
      $error("register number outside the file");
   end

   logic [IDX_W-1:0]  idx_q;
   logic [DATA_W-1:0] regs_q [DEPTH];
   logic [DATA_W-1:0] stat_view;
   logic [DATA_W-1:0] sel_byte;
   logic              hit_idx_rd, hit_dat_rd;

   xr_regfile #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .idx_we (port_hit(io_wr, io_addr, INDEX_PORT)),
      .dat_we (port_hit(io_wr, io_addr, DATA_PORT)),
      .wdata  (io_wdata),
      .idx_q  (idx_q),
      .regs_q (regs_q)
   );

   xr_bank_map #(.BANK_W(BANK_W), .GRAN_W(GRAN_W), .SPLIT_EN(SPLIT_EN)) u_bank (
      .mode_bit (regs_q[MODE_REG][MODE_BIT]),
      .rd_field (regs_q[BANK_REG][RD_LSB +: BANK_W]),
      .wr_field (regs_q[BANK_REG][WR_LSB +: BANK_W]),
      .rd_base  (rd_bank_base),
      .wr_base  (wr_bank_base)
   );

   xr_eeprom_port #(.DATA_W(DATA_W)) u_ee (
      .ctrl_byte (regs_q[EE_CTRL_REG]),
      .stat_byte (regs_q[EE_STAT_REG]),
      .ee_dout   (ee_dout),
      .ee_cs     (ee_cs),
      .ee_clk    (ee_clk),
      .ee_din    (ee_din),
      .stat_view (stat_view)
   );

   assign hit_idx_rd = port_hit(io_rd, io_addr, INDEX_PORT);
   assign hit_dat_rd = port_hit(io_rd, io_addr, DATA_PORT);
   assign sel_byte   = (idx_q == IDX_W'(EE_STAT_REG)) ? stat_view : regs_q[idx_q];

   always_comb begin
      io_rdata = '0;
      if (hit_idx_rd)      io_rdata = DATA_W'(idx_q);
      else if (hit_dat_rd) io_rdata = sel_byte;
   end
endmodule

// File: rtl/xr_mapper_checker.sv
module xr_mapper_checker #(
   parameter logic [15:0] INDEX_PORT = 16'h01CE,
   parameter logic [15:0] DATA_PORT  = 16'h01CF
) (
   input logic        clk,
   input logic        rst_n,
   input logic [15:0] io_addr,
   input logic [7:0]  io_wdata,
   input logic        io_wr,
   input logic        io_rd,
   input logic [7:0]  io_rdata,
   input logic        ee_dout,
   input logic [18:0] rd_bank_base,
   input logic [18:0] wr_bank_base,
   input logic        ee_cs,
   input logic        ee_clk,
   input logic        ee_din
);
   logic [7:0] sh_idx, sh_bank, sh_mode;
   logic       wr_dat;

   assign wr_dat = io_wr && io_addr == DATA_PORT;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_idx  <= '0;
         sh_bank <= '0;
         sh_mode <= '0;
      end else begin
         if (io_wr && io_addr == INDEX_PORT) sh_idx <= io_wdata;
         if (wr_dat && sh_idx == 8'hB2) sh_bank <= io_wdata;
         if (wr_dat && sh_idx == 8'hBE) sh_mode <= io_wdata;
      end
   end

   AST_INDEX_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
      (io_rd && io_addr == INDEX_PORT) |-> io_rdata == sh_idx); // R1
   AST_SPLIT_BANKS: assert property (@(posedge clk) disable iff (!rst_n)
      sh_mode[3] |-> (rd_bank_base[18:16] == sh_bank[7:5]
                      && wr_bank_base[18:16] == sh_bank[3:1])); // R3
   AST_SHARED_BANKS: assert property (@(posedge clk) disable iff (!rst_n)
      !sh_mode[3] |-> (rd_bank_base == wr_bank_base
                       && wr_bank_base[18:16] == sh_bank[3:1])); // R4
   AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !io_wr |=> ($stable(rd_bank_base) && $stable(wr_bank_base))); // R5
   AST_EE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !io_wr |=> ($stable(ee_cs) && $stable(ee_clk) && $stable(ee_din))); // R6
   AST_STATUS_PIN: assert property (@(posedge clk) disable iff (!rst_n)
      (io_rd && io_addr == DATA_PORT && sh_idx == 8'hB7) |-> io_rdata[3] == ee_dout); // R7
   AST_READ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !io_rd |-> io_rdata == 8'h00); // R9
   AST_NO_DUAL_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      !(io_rd && io_wr)); // R9
endmodule

bind ext_reg_bank_mapper xr_mapper_checker #(
   .INDEX_PORT(INDEX_PORT), .DATA_PORT(DATA_PORT)
) u_checker (
   .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
   .io_wr(io_wr), .io_rd(io_rd), .io_rdata(io_rdata), .ee_dout(ee_dout),
   .rd_bank_base(rd_bank_base), .wr_bank_base(wr_bank_base),
   .ee_cs(ee_cs), .ee_clk(ee_clk), .ee_din(ee_din)
);

// File: tb/ext_reg_bank_mapper_bench.sv
module ext_reg_bank_mapper_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] io_addr = '0;
   logic [7:0]  io_wdata = '0;
   logic        io_wr = 1'b0;
   logic        io_rd = 1'b0;
   logic [7:0]  io_rdata;
   logic        ee_dout = 1'b0;
   logic [18:0] rd_bank_base, wr_bank_base;
   logic        ee_cs, ee_clk, ee_din;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   ext_reg_bank_mapper u_ext_reg_bank_mapper (
      .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
      .io_wr(io_wr), .io_rd(io_rd), .io_rdata(io_rdata), .ee_dout(ee_dout),
      .rd_bank_base(rd_bank_base), .wr_bank_base(wr_bank_base),
      .ee_cs(ee_cs), .ee_clk(ee_clk), .ee_din(ee_din)
   );

   // Vector: {op, addr, data/expected}; op 0 = write, 1 = read and compare.
   localparam int NV = 20;
   localparam logic [24:0] VEC [NV] = '{
      {1'b0, 16'h01CE, 8'h10},  // R1 set index
      {1'b1, 16'h01CE, 8'h10},  // R1
      {1'b0, 16'h01CF, 8'h5A},  // R2
      {1'b1, 16'h01CF, 8'h5A},  // R2
      {1'b0, 16'h01CE, 8'h11},
      {1'b0, 16'h01CF, 8'hA5},
      {1'b1, 16'h01CF, 8'hA5},  // R2
      {1'b0, 16'h01CE, 8'h10},
      {1'b1, 16'h01CF, 8'h5A},  // R2 earlier entry untouched
      {1'b0, 16'h01CE, 8'hFF},
      {1'b0, 16'h01CF, 8'h3C},
      {1'b1, 16'h01CF, 8'h3C},  // R2 top entry
      {1'b1, 16'h01CE, 8'hFF},  // R1
      {1'b1, 16'h01CD, 8'h00},  // R9 undecoded read
      {1'b0, 16'h03CF, 8'h77},  // R9 foreign write
      {1'b1, 16'h01CF, 8'h3C},  // R9 no change
      {1'b0, 16'h01CE, 8'hB7},
      {1'b0, 16'h01CF, 8'hFF},
      {1'b1, 16'h01CF, 8'hF7},  // R7 pin low
      {1'b1, 16'h01CE, 8'hB7}   // R1
   };

   task automatic check8(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      io_addr = a; io_wdata = d; io_wr = 1'b1;
      @(negedge clk);
      io_wr = 1'b0;
   endtask

   task automatic bus_rd(input string tag, input logic [15:0] a, input logic [7:0] exp);
      @(negedge clk);
      io_addr = a; io_rd = 1'b1;
      #2 check8(tag, 32'(io_rdata), 32'(exp));
      @(negedge clk);
      io_rd = 1'b0;
   endtask

   task automatic reg_wr(input logic [7:0] r, input logic [7:0] d);
      bus_wr(16'h01CE, r);
      bus_wr(16'h01CF, d);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R8 reset state
      check8("R8 rd base", 32'(rd_bank_base), 32'h0);
      check8("R8 wr base", 32'(wr_bank_base), 32'h0);
      check8("R8 ee lines", {29'd0, ee_cs, ee_clk, ee_din}, 32'h0);
      bus_rd("R8 index", 16'h01CE, 8'h00);
      bus_rd("R8 reg0", 16'h01CF, 8'h00);

      for (int i = 0; i < NV; i++) begin
         if (VEC[i][24]) bus_rd($sformatf("R1/R2/R7/R9 vec%0d", i), VEC[i][23:8], VEC[i][7:0]);
         else            bus_wr(VEC[i][23:8], VEC[i][7:0]);
      end

      // R4 shared mode: 0xB2=0xAC -> rd field 5, wr field 6
      reg_wr(8'hB2, 8'hAC);
      @(negedge clk);
      check8("R4 shared rd", 32'(rd_bank_base), 32'h60000);
      check8("R5 shared wr", 32'(wr_bank_base), 32'h60000);
      // R3 split mode
      reg_wr(8'hBE, 8'h08);
      check8("R3 split rd", 32'(rd_bank_base), 32'h50000);
      check8("R3 split wr", 32'(wr_bank_base), 32'h60000);
      reg_wr(8'hB2, 8'hEE);
      check8("R3 split rd max", 32'(rd_bank_base), 32'h70000);
      check8("R5 split wr max", 32'(wr_bank_base), 32'h70000);
      // R4 other mode bits ignored
      reg_wr(8'hBE, 8'hF7);
      reg_wr(8'hB2, 8'h04);
      check8("R4 mode bits rd", 32'(rd_bank_base), 32'h20000);
      check8("R4 mode bits wr", 32'(wr_bank_base), 32'h20000);

      // R6 EEPROM lines
      reg_wr(8'hB3, 8'h0B);
      check8("R6 all high", {29'd0, ee_cs, ee_clk, ee_din}, 32'h7);
      reg_wr(8'hB3, 8'h08);
      check8("R6 cs only", {29'd0, ee_cs, ee_clk, ee_din}, 32'h4);
      reg_wr(8'hB3, 8'hF4);
      check8("R6 other bits", {29'd0, ee_cs, ee_clk, ee_din}, 32'h0);
      reg_wr(8'hB1, 8'hFF);
      check8("R6 hold", {29'd0, ee_cs, ee_clk, ee_din}, 32'h0);

      // R7 status pin high
      ee_dout = 1'b1;
      reg_wr(8'hB7, 8'h00);
      bus_rd("R7 pin high", 16'h01CF, 8'h08);
      ee_dout = 1'b0;
      bus_rd("R7 pin low", 16'h01CF, 8'h00);

      // R9 idle read
      @(negedge clk);
      io_addr = 16'h01CE;
      #2 check8("R9 idle rdata", 32'(io_rdata), 32'h0);

      // R8 reset mid-run
      reg_wr(8'hB2, 8'hFE);
      reg_wr(8'hB3, 8'h0B);
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      check8("R8 rerst rd base", 32'(rd_bank_base), 32'h0);
      check8("R8 rerst ee", {29'd0, ee_cs, ee_clk, ee_din}, 32'h0);
      bus_rd("R8 rerst index", 16'h01CE, 8'h00);
      bus_wr(16'h01CE, 8'hB2);
      bus_rd("R8 rerst reg", 16'h01CF, 8'h00);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual hung expected done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule